// File: doc/BRIEF.md
# Multi-Mode Buzzer Tone Generator

This block drives a buzzer with a 50 % duty square wave. It derives the tone from a 12 kHz reference tick and can produce four pitches. A small cadence sequencer gates the tone in one of four patterns:

- steady tone for as long as the block is enabled,
- one 100 ms beep,
- a 10 Hz chop of 50 ms on and 50 ms off,
- the 10 Hz chop for the first half of every second, then silence for the second half.

Frequency, pattern and enable come from control bits that a processor writes. A busy flag tells software that a one-shot beep is still sounding.

The sequencer is a five-state machine:

- `ST_IDLE`: disabled, output low.
- `ST_SOUND`: the tone is gated through to the pin.
- `ST_GAP`: the 50 ms silent half of the chop.
- `ST_REST`: the silent half-second of the burst pattern.
- `ST_SPENT`: the one-shot beep has finished.

Its transitions are:

- **start**: `ST_IDLE` to `ST_SOUND` when enable is sampled high.
- **chop**: `ST_SOUND` to `ST_GAP` at the end of a 50 ms segment, in the chop and burst patterns.
- **resume**: `ST_GAP` to `ST_SOUND` at the end of a segment.
- **park**: `ST_GAP` to `ST_REST` at the end of the fifth gap of a second, in the burst pattern.
- **wake**: `ST_REST` to `ST_SOUND` when the one-second frame wraps.
- **expire**: `ST_SOUND` to `ST_SPENT` after 100 ms, in one-shot mode.
- **stop**: any state to `ST_IDLE` when enable is sampled low.

Top module: `buzz_tone_gen`

## Requirements
- R1: The pitch is set by `pitch_sel`. Code 0 divides the tick by 16 (750 Hz), code 1 by 12 (1 kHz), code 2 by 8 (1.5 kHz) and code 3 by 4 (3 kHz). The tone starts high on the first clock after start, and after every further divisor/2 ticks it toggles.
- R2: Pattern code 0 (steady) sounds the tone for as long as `enable` stays high.
- R3: Pattern code 1 (one-shot) sounds the tone for the first 1200 ticks (100 ms) after start and then goes silent.
- R4: `busy` is high exactly while a one-shot beep is sounding, and it is low in every other pattern and state.
- R5: After a one-shot beep ends, the output stays low and `busy` stays low while `enable` remains high. A new beep starts only after `enable` has been sampled low and then high again.
- R6: Pattern code 2 (chop) repeats 600 ticks with the tone and 600 ticks of silence, starting with the tone.
- R7: Pattern code 3 (burst) runs the chop for ticks 0 to 5999 of each 12000-tick frame, holds the output low for ticks 6000 to 11999, and repeats.
- R8: In reset, and one clock after `enable` is sampled low, both `buzz_out` and `busy` are low.
- R9: Re-enabling the block restarts the tone phase, the cadence segment and the frame from tick 0.
- R10: Between ticks the output holds its level. The tone phase and the cadence advance only on clocks where `tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-clock strobe at the 12 kHz reference rate |
| pitch_sel | input | 2 | Tone divisor select (see R1) |
| mode_sel | input | 2 | Cadence pattern select (see R2, R3, R6, R7) |
| enable | input | 1 | Run request, level sensitive |
| buzz_out | output | 1 | Square-wave buzzer drive |
| busy | output | 1 | One-shot beep in progress |

## Verification
Two functions fall on the same tick at the end of a one-shot beep when the lowest pitch is selected: the shot timer expires and the tone divider toggles. The bench runs that case at 750 Hz and expects the output low, not an inverted tone, on the clock after tick 1200. In burst mode the segment boundary and the half-second frame boundary coincide at tick 6000. The bench expects the rest phase, not another sounding segment, at that point and again one frame later. A run of sparse ticks confirms that the two counters move only on strobes.

// File: rtl/buzz_pkg.sv
package buzz_pkg;

    typedef enum logic [1:0] {
        MODE_STEADY = 2'd0,
        MODE_SHOT   = 2'd1,
        MODE_CHOP   = 2'd2,
        MODE_BURST  = 2'd3
    } mode_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SOUND = 3'd1,
        ST_GAP   = 3'd2,
        ST_REST  = 3'd3,
        ST_SPENT = 3'd4
    } state_e;

    localparam int HALF_W = 4;

    // Ticks per half period of the square wave for each pitch code.
    function automatic logic [HALF_W-1:0] half_ticks(input logic [1:0] sel);
        logic [HALF_W-1:0] h;
        unique case (sel)
            2'd0:    h = 4'd8;
            2'd1:    h = 4'd6;
            2'd2:    h = 4'd4;
            default: h = 4'd2;
        endcase
        return h;
    endfunction

endpackage

// File: rtl/buzz_tone_div.sv
module buzz_tone_div
    import buzz_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       adv,
    input  logic [1:0] pitch_sel,
    output logic       tone_lvl
);

    logic [HALF_W-1:0] ph_cnt;
    logic [HALF_W-1:0] half_m1;

    always_comb begin
        half_m1 = half_ticks(pitch_sel) - HALF_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ph_cnt   <= '0;
            tone_lvl <= 1'b1;
        end else if (adv) begin
            if (ph_cnt >= half_m1) begin
                ph_cnt   <= '0;
                tone_lvl <= ~tone_lvl;
            end else begin
                ph_cnt <= ph_cnt + HALF_W'(1);
            end
        end
    end

endmodule

// File: rtl/buzz_cadence_cnt.sv
module buzz_cadence_cnt #(
    parameter int SEG_TICKS   = 600,
    parameter int SHOT_TICKS  = 1200,
    parameter int BURST_TICKS = 6000,
    parameter int FRAME_TICKS = 12000
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clr,
    input  logic                           seg_adv,
    input  logic                           frame_adv,
    output logic [$clog2(SEG_TICKS)-1:0]   seg_cnt,
    output logic [$clog2(FRAME_TICKS)-1:0] frame_cnt,
    output logic                           seg_last,
    output logic                           shot_last,
    output logic                           burst_last,
    output logic                           frame_last
);

    localparam int SEG_W   = $clog2(SEG_TICKS);
    localparam int FRAME_W = $clog2(FRAME_TICKS);
    localparam logic [SEG_W-1:0]   SEG_END   = SEG_W'(SEG_TICKS - 1);
    localparam logic [FRAME_W-1:0] SHOT_END  = FRAME_W'(SHOT_TICKS - 1);
    localparam logic [FRAME_W-1:0] BURST_END = FRAME_W'(BURST_TICKS - 1);
    localparam logic [FRAME_W-1:0] FRAME_END = FRAME_W'(FRAME_TICKS - 1);

    always_comb begin
        seg_last   = (seg_cnt == SEG_END);
        shot_last  = (frame_cnt == SHOT_END);
        burst_last = (frame_cnt == BURST_END);
        frame_last = (frame_cnt == FRAME_END);
    end

    // 50 ms segment counter: runs only while the pattern is sounding or gapped
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            seg_cnt <= '0;
        end else if (seg_adv) begin
            seg_cnt <= seg_last ? '0 : seg_cnt + SEG_W'(1);
        end
    end

    // one-second frame counter: position since start, wraps each frame
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            frame_cnt <= '0;
        end else if (frame_adv) begin
            frame_cnt <= frame_last ? '0 : frame_cnt + FRAME_W'(1);
        end
    end

endmodule

// File: rtl/buzz_seq_fsm.sv
module buzz_seq_fsm
    import buzz_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       tick,
    input  logic [1:0] mode_sel,
    input  logic       seg_last,
    input  logic       shot_last,
    input  logic       burst_last,
    input  logic       frame_last,
    output state_e     state
);

    state_e nxt;
    mode_e  mode;

    always_comb begin
        mode = mode_e'(mode_sel);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (enable) nxt = ST_SOUND;                   // start
            end
            ST_SOUND: begin
                if (!enable) begin
                    nxt = ST_IDLE;                            // stop
                end else if (tick) begin
                    unique case (mode)
                        MODE_SHOT:  if (shot_last) nxt = ST_SPENT;   // expire
                        MODE_CHOP,
                        MODE_BURST: if (seg_last)  nxt = ST_GAP;     // chop
                        default:    nxt = ST_SOUND;
                    endcase
                end
            end
            ST_GAP: begin
                if (!enable) begin
                    nxt = ST_IDLE;                            // stop
                end else if (tick && seg_last) begin
                    if (mode == MODE_BURST && burst_last) begin
                        nxt = ST_REST;                        // park
                    end else begin
                        nxt = ST_SOUND;                       // resume
                    end
                end
            end
            ST_REST: begin
                if (!enable) begin
                    nxt = ST_IDLE;                            // stop
                end else if (tick && frame_last) begin
                    nxt = ST_SOUND;                           // wake
                end
            end
            ST_SPENT: begin
                if (!enable) nxt = ST_IDLE;                   // stop
            end
            default: nxt = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/buzz_tone_gen.sv
module buzz_tone_gen
    import buzz_pkg::*;
#(
    parameter int TICK_RATE = 12000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] pitch_sel,
    input  logic [1:0] mode_sel,
    input  logic       enable,
    output logic       buzz_out,
    output logic       busy
);

    localparam int SEG_TICKS   = TICK_RATE / 20;
    localparam int SHOT_TICKS  = TICK_RATE / 10;
    localparam int BURST_TICKS = TICK_RATE / 2;
    localparam int FRAME_TICKS = TICK_RATE;
    localparam int SEG_W       = $clog2(SEG_TICKS);
    localparam int FRAME_W     = $clog2(FRAME_TICKS);

    state_e             state;
    logic               tone_lvl;
    logic               running;
    logic               chopping;
    logic               hold_clr;
    logic [SEG_W-1:0]   seg_cnt;
    logic [FRAME_W-1:0] frame_cnt;
    logic               seg_last;
    logic               shot_last;
    logic               burst_last;
    logic               frame_last;

    always_comb begin
        running  = (state == ST_SOUND) || (state == ST_GAP) || (state == ST_REST);
        chopping = (state == ST_SOUND) || (state == ST_GAP);
        hold_clr = !running;
    end

    buzz_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .tick       (tick),
        .mode_sel   (mode_sel),
        .seg_last   (seg_last),
        .shot_last  (shot_last),
        .burst_last (burst_last),
        .frame_last (frame_last),
        .state      (state)
    );

    buzz_cadence_cnt #(
        .SEG_TICKS   (SEG_TICKS),
        .SHOT_TICKS  (SHOT_TICKS),
        .BURST_TICKS (BURST_TICKS),
        .FRAME_TICKS (FRAME_TICKS)
    ) u_cad (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (hold_clr),
        .seg_adv    (tick && chopping),
        .frame_adv  (tick && running),
        .seg_cnt    (seg_cnt),
        .frame_cnt  (frame_cnt),
        .seg_last   (seg_last),
        .shot_last  (shot_last),
        .burst_last (burst_last),
        .frame_last (frame_last)
    );

    buzz_tone_div u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (hold_clr),
        .adv       (tick && running),
        .pitch_sel (pitch_sel),
        .tone_lvl  (tone_lvl)
    );

    // output process
    always_comb begin
        buzz_out = (state == ST_SOUND) && tone_lvl;
        busy     = (state == ST_SOUND) && (mode_e'(mode_sel) == MODE_SHOT);
    end

endmodule

// File: rtl/buzz_tone_gen_chk.sv
module buzz_tone_gen_chk
    import buzz_pkg::*;
#(
    parameter int SEG_TICKS   = 600,
    parameter int SHOT_TICKS  = 1200,
    parameter int FRAME_TICKS = 12000
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           tick,
    input logic                           enable,
    input logic [1:0]                     mode_sel,
    input logic                           buzz_out,
    input logic                           busy,
    input logic                           tone_lvl,
    input state_e                         state,
    input logic [$clog2(SEG_TICKS)-1:0]   seg_cnt,
    input logic [$clog2(FRAME_TICKS)-1:0] frame_cnt
);

    assert_quiet_after_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!buzz_out && !busy));

    assert_sound_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        buzz_out |-> $past(enable));

    assert_phase_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(tick) && state != ST_IDLE && $past(state) != ST_IDLE) |-> $stable(tone_lvl));

    assert_busy_in_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (32'(frame_cnt) < SHOT_TICKS));

    assert_spent_stays_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && enable && $past(enable) && mode_sel == 2'd1 && $past(mode_sel) == 2'd1)
        |=> (!busy && !buzz_out));

    assert_seg_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        32'(seg_cnt) < SEG_TICKS);

    assert_frame_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        32'(frame_cnt) < FRAME_TICKS);

endmodule

bind buzz_tone_gen buzz_tone_gen_chk #(
    .SEG_TICKS   (SEG_TICKS),
    .SHOT_TICKS  (SHOT_TICKS),
    .FRAME_TICKS (FRAME_TICKS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .enable    (enable),
    .mode_sel  (mode_sel),
    .buzz_out  (buzz_out),
    .busy      (busy),
    .tone_lvl  (tone_lvl),
    .state     (state),
    .seg_cnt   (seg_cnt),
    .frame_cnt (frame_cnt)
);

// File: tb/buzz_tone_gen_test.sv
module buzz_tone_gen_test;

    typedef struct {
        logic  buzz;
        logic  bsy;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [1:0] pitch_sel = 2'd0;
    logic [1:0] mode_sel = 2'd0;
    logic       enable = 1'b0;
    logic       buzz_out;
    logic       busy;

    int   checks = 0;
    int   errors = 0;
    int   t = 0;
    bit   run = 0;
    bit   finished = 0;
    exp_t q[$];

    always #10 clk = ~clk;

    buzz_tone_gen uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .pitch_sel (pitch_sel),
        .mode_sel  (mode_sel),
        .enable    (enable),
        .buzz_out  (buzz_out),
        .busy      (busy)
    );

    function automatic int half_of(input logic [1:0] s);
        case (s)
            2'd0:    return 8;
            2'd1:    return 6;
            2'd2:    return 4;
            default: return 2;
        endcase
    endfunction

    function automatic bit gate_of(input logic [1:0] m, input int tt);
        case (m)
            2'd0:    return 1'b1;
            2'd1:    return tt < 1200;
            2'd2:    return (tt % 1200) < 600;
            default: return ((tt % 12000) < 6000) && ((tt % 1200) < 600);
        endcase
    endfunction

    // driver: applies one clock of stimulus and queues the expected outputs
    task automatic drive(input logic en, input logic tk, input string tag);
        exp_t it;
        @(negedge clk);
        enable = en;
        tick   = tk;
        if (!en) begin
            run = 0;
        end else if (!run) begin
            run = 1;
            t   = 0;
        end else if (tk) begin
            t++;
        end
        it.buzz = run && gate_of(mode_sel, t) && (((t / half_of(pitch_sel)) % 2) == 0);
        it.bsy  = run && (mode_sel == 2'd1) && (t < 1200);
        it.tag  = tag;
        q.push_back(it);
    endtask

    task automatic run_ticks(input int n, input int spacing, input string tag);
        for (int i = 0; i < n; i++) begin
            for (int k = 1; k < spacing; k++) drive(1'b1, 1'b0, tag);
            drive(1'b1, 1'b1, tag);
        end
    endtask

    task automatic go_idle(input int n, input string tag);
        for (int i = 0; i < n; i++) drive(1'b0, 1'b1, tag);
    endtask

    // monitor: compares each queued item after the edge that produced it
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (q.size() > 0) begin
                exp_t it;
                it = q.pop_front();
                checks++;
                if (buzz_out !== it.buzz) begin
                    errors++;
                    $display("FAIL %s buzz_out t=%0d actual=%b expected=%b", it.tag, t, buzz_out, it.buzz);
                end
                checks++;
                if (busy !== it.bsy) begin
                    errors++;
                    $display("FAIL R4 (%s) busy t=%0d actual=%b expected=%b", it.tag, t, busy, it.bsy);
                end
            end
        end
    end

    initial begin
        #(64'd20 * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        checks++;
        if (buzz_out !== 1'b0 || busy !== 1'b0) begin
            errors++;
            $display("FAIL R8 reset outputs actual=%b%b expected=00", buzz_out, busy);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R1: every pitch code in steady mode
        mode_sel = 2'd0;
        for (int p = 3; p >= 0; p--) begin
            pitch_sel = 2'(p);
            run_ticks(70, 1, "R1");
            go_idle(2, "R8");
        end

        // R2: steady tone over a long stretch
        pitch_sel = 2'd1;
        run_ticks(400, 1, "R2");
        go_idle(3, "R8");

        // R10: sparse ticks, output must hold between strobes
        pitch_sel = 2'd3;
        run_ticks(40, 3, "R10");
        go_idle(2, "R8");

        // R3/R4: one-shot at the lowest pitch, end coincides with a toggle
        mode_sel  = 2'd1;
        pitch_sel = 2'd0;
        run_ticks(1300, 1, "R3");
        // R5: enable held high after the shot stays silent
        run_ticks(200, 1, "R5");
        go_idle(2, "R5");
        run_ticks(100, 1, "R5");
        go_idle(2, "R8");

        // R6: chop pattern
        mode_sel  = 2'd2;
        pitch_sel = 2'd2;
        run_ticks(2500, 1, "R6");
        go_idle(1, "R8");
        // R9: restart mid-pattern, cadence begins again at tick 0
        run_ticks(900, 1, "R9");
        go_idle(2, "R9");
        run_ticks(1300, 1, "R9");
        go_idle(2, "R8");

        // R7: burst pattern over two full frames
        mode_sel  = 2'd3;
        pitch_sel = 2'd1;
        run_ticks(25000, 1, "R7");
        go_idle(3, "R8");

        while (q.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule